// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic read and write single bytes in an external asynchronous static RAM of 32768 bytes (15 address bits, 8 data bits). The user raises a request together with a direction flag, an address and, for writes, a data byte. The request is taken only while `ready_o` is high. When the access completes, the controller returns a one-cycle `done_o` pulse, and for a read the byte arrives on `rdata_o` in the same cycle.

On the memory side the controller drives active-low select, write and output-enable strobes and the address bus. The data bus is split into outgoing data, incoming data and a driver-enable. Wait states are counted in clock cycles. Each count is the ceiling of a nanosecond limit divided by the clock period, so the same RTL works for any clock and any speed grade of the memory.

Writes are always strobed by the write-enable line, and output enable stays high for the whole write. For that reason the write pulse only has to meet the pulse-width limit and the data-setup limit. Between accesses the memory is left deselected, which keeps it in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ready_o`=1, `done_o`=0, all three memory strobes are 1 and `mem_dq_oe_o`=0.
- R2: A request is accepted only on a clock edge where `req_i`=1 and `ready_o`=1. `ready_o` is 0 from the accept edge until the access completes, and a request raised during that time has no effect on the memory or on `done_o`.
- R3: A read (`wr_i`=0) holds select low, output enable low and write enable high. It captures the data bus RD_CYC cycles after the accept edge, where RD_CYC = max(ceil(T_AA/T_CLK), ceil(T_RC/T_CLK)). `done_o` rises at that same edge, with `rdata_o` equal to the byte stored at the address.
- R4: During a write (`wr_i`=1), output enable stays 1. Write enable is low for exactly PULSE_CYC = max(ceil(T_WP/T_CLK), ceil(T_DW/T_CLK)+1) consecutive cycles.
- R5: `mem_dq_oe_o` is 1 only while write enable is low and was already low in the previous cycle. It is 1 for at least ceil(T_DW/T_CLK) cycles before write enable rises.
- R6: While write enable is low, `mem_addr_o` does not change.
- R7: Whenever `ready_o`=1, select is 1 (standby).
- R8: `done_o` lasts exactly one cycle. For a write it rises 1+PULSE_CYC cycles after the accept edge, and the byte then reads back from that address.
- R9: Write enable is never low while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Byte address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Idle, able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with done_o |
| mem_addr_o | output | 15 | Memory address bus |
| mem_cs_n_o | output | 1 | Memory select, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_i | input | 8 | Data returned by the memory |
| mem_dq_oe_o | output | 1 | Enable for the data drivers |

## Verification
The bench builds the controller for an 8 ns clock with a 20 ns access and cycle time, a 9 ns pulse width and a 12 ns data setup. That gives a 3-cycle read and a 3-cycle write pulse, in which the data-setup term outweighs the pulse-width term, so the max() choice in R4 is exercised. The memory model returns data only after a 20 ns delay, so a read that samples one cycle early captures stale data. Addresses 0 and 0x7FFF cover the ends of the address range.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and constant helpers for the SRAM access controller.
// Assumes all timing arguments are positive integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WSET  = 2'd2,
        ST_WPUL  = 2'd3
    } sram_st_e;

    // Ceiling of a / b, never below 1.
    function automatic int cdiv(input int a, input int b);
        int q;
        q = (a + b - 1) / b;
        return (q < 1) ? 1 : q;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
// Down-counter that times wait states.
// Loading with N-1 makes last_o high in the N-th cycle after the load edge.
// Assumes the load value fits in CNT_W bits.
module sram_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load the wait count, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_wr_path.sv
`timescale 1ns/1ps
// Holds the address and write data of the current access, and registers
// the data-driver enable so that it turns on one cycle after write enable falls.
// Assumes load_i is high only on the accept edge.
module sram_wr_path #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              drv_d_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              drv_o
);
    // Capture address and data when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            wdata_o <= '0;
        end else if (load_i) begin
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
        end
    end

    // Registered data-bus driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drv_o <= 1'b0;
        else
            drv_o <= drv_d_i;
    end
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
// Samples the memory data bus at the end of a read and produces the
// one-cycle completion pulse for reads and writes.
// Assumes cap_i and fin_i are single-cycle strobes.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              fin_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);
    // Register the read byte on the final wait-state clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (cap_i)
            rdata_o <= dq_i;
    end

    // Completion pulse, aligned with the registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_o <= 1'b0;
        else
            done_o <= fin_i;
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Synchronous controller for an asynchronous byte-wide SRAM.
// Reads hold select and output enable low for RD_CYC cycles and sample the
// bus on the last one. Writes spend one setup cycle with only select low,
// then hold write enable low for PULSE_CYC cycles with output enable high.
// Assumes the memory needs 0 ns address setup, write recovery and data hold.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_AA_NS       = 10,
    parameter int T_RC_NS       = 10,
    parameter int T_WP_NS       = 9,
    parameter int T_DW_NS       = 6,
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_n_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe_o
);
    localparam int RD_CYC    = imax(cdiv(T_AA_NS, CLK_PERIOD_NS), cdiv(T_RC_NS, CLK_PERIOD_NS));
    localparam int WP_CYC    = cdiv(T_WP_NS, CLK_PERIOD_NS);
    localparam int DS_CYC    = cdiv(T_DW_NS, CLK_PERIOD_NS);
    localparam int PULSE_CYC = imax(WP_CYC, DS_CYC + 1);
    localparam int CNT_MAX   = imax(RD_CYC, PULSE_CYC);
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    sram_st_e         state_q, state_d;
    logic             tmr_load, tmr_last, accept;
    logic [CNT_W-1:0] tmr_val;

    assign accept = (state_q == ST_IDLE) && req_i;

    // Next-state and wait-timer load decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: if (req_i) begin
                state_d = wr_i ? ST_WSET : ST_READ;
                if (!wr_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RD_CYC - 1);
                end
            end
            ST_READ: if (tmr_last) state_d = ST_IDLE;
            ST_WSET: begin
                state_d  = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PULSE_CYC - 1);
            end
            ST_WPUL: if (tmr_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    sram_wait_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .last_o     (tmr_last)
    );

    sram_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wrp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .drv_d_i ((state_q == ST_WPUL) && !tmr_last),
        .addr_o  (mem_addr_o),
        .wdata_o (mem_dq_o),
        .drv_o   (mem_dq_oe_o)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   ((state_q == ST_READ) && tmr_last),
        .fin_i   (((state_q == ST_READ) || (state_q == ST_WPUL)) && tmr_last),
        .dq_i    (mem_dq_i),
        .rdata_o (rdata_o),
        .done_o  (done_o)
    );

    assign ready_o    = (state_q == ST_IDLE);
    assign mem_cs_n_o = (state_q == ST_IDLE);
    assign mem_oe_n_o = (state_q != ST_READ);
    assign mem_we_n_o = (state_q != ST_WPUL);
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for sram_async_ctrl, attached with bind.
// Observes only the ports of the controller.
module sram_async_ctrl_chk #(
    parameter int ADDR_W    = 15,
    parameter int PULSE_CYC = 2,
    parameter int DS_CYC    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              done,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [ADDR_W-1:0] addr
);
    int we_low_cnt, drv_cnt;

    // Count the cycles of the current write-enable pulse and of driver enable inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= 0;
            drv_cnt    <= 0;
        end else if (!we_n) begin
            we_low_cnt <= we_low_cnt + 1;
            drv_cnt    <= drv_cnt + (dq_oe ? 1 : 0);
        end else begin
            we_low_cnt <= 0;
            drv_cnt    <= 0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (ready && cs_n && we_n && oe_n && !dq_oe && !done));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !ready);

    assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !cs_n));

    assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_cnt == PULSE_CYC));

    assert_drv_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && !$past(we_n)));

    assert_drv_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (drv_cnt >= DS_CYC));

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !$past(we_n)) |-> $stable(addr));

    assert_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cs_n);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_we_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC),
    .DS_CYC    (DS_CYC)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (ready_o),
    .done  (done_o),
    .cs_n  (mem_cs_n_o),
    .we_n  (mem_we_n_o),
    .oe_n  (mem_oe_n_o),
    .dq_oe (mem_dq_oe_o),
    .addr  (mem_addr_o)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected completions, the monitor
// pops them on done_o and also checks the memory-side strobes every cycle.
module sram_async_ctrl_tb_top;
    localparam int TCLK = 8;
    localparam int T_AA = 20;
    localparam int T_RC = 20;
    localparam int T_WP = 9;
    localparam int T_DW = 12;
    localparam int RD_LAT = 3;        // ceil(20/8)
    localparam int DS     = 2;        // ceil(12/8)
    localparam int PULSE  = 3;        // max(ceil(9/8), DS+1)
    localparam int WR_LAT = 1 + PULSE;

    typedef struct {
        bit          is_rd;
        logic [14:0] addr;
        logic [7:0]  data;
        int          acc;
        int          lat;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, wr_i = 1'b0;
    logic [14:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        ready_o, done_o, mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o;
    logic [7:0]  rdata_o, mem_dq_o, mem_dq_i;
    logic [14:0] mem_addr_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    item_t sb_q[$];
    logic [7:0] mem_m [int];
    logic [7:0] ref_m [int];

    always #(TCLK/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_async_ctrl #(
        .CLK_PERIOD_NS(TCLK), .T_AA_NS(T_AA), .T_RC_NS(T_RC),
        .T_WP_NS(T_WP), .T_DW_NS(T_DW), .ADDR_W(15), .DATA_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o),
        .done_o(done_o), .rdata_o(rdata_o), .mem_addr_o(mem_addr_o),
        .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o),
        .mem_oe_n_o(mem_oe_n_o), .mem_dq_o(mem_dq_o),
        .mem_dq_i(mem_dq_i), .mem_dq_oe_o(mem_dq_oe_o)
    );

    function automatic logic [7:0] init_val(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] model_rd(input logic [14:0] a);
        return mem_m.exists(int'(a)) ? mem_m[int'(a)] : init_val(a);
    endfunction

    // Memory model: data appears one access time after the read strobes settle.
    assign #(T_AA) mem_dq_i = (!mem_cs_n_o && !mem_oe_n_o && mem_we_n_o) ? model_rd(mem_addr_o) : 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit poke);
        item_t it;
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        req_i = 1'b1; wr_i = wr; addr_i = a; wdata_i = d;
        @(negedge clk);
        it.is_rd = !wr; it.addr = a; it.acc = cyc;
        it.lat   = wr ? WR_LAT : RD_LAT;
        if (wr) begin
            it.data = d;
            ref_m[int'(a)] = d;
        end else begin
            it.data = ref_m.exists(int'(a)) ? ref_m[int'(a)] : init_val(a);
        end
        sb_q.push_back(it);
        req_i = 1'b0;
        if (poke) begin
            chk(ready_o == 1'b0, "R2 ready low while busy", ready_o, 0);
            req_i = 1'b1; wr_i = 1'b1; addr_i = 15'h4321; wdata_i = 8'h99;
            @(negedge clk);
            req_i = 1'b0;
        end
    endtask

    // Monitor: scoreboard compare and per-cycle strobe checks.
    int  we_cnt = 0, drv_cnt = 0;
    logic [14:0] we_addr = '0;
    logic prev_we_n = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2 done with nothing pending", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (it.is_rd) begin
                        chk(rdata_o == it.data, "R3 read data", rdata_o, it.data);
                        chk(cyc - it.acc == it.lat, "R3 read latency", cyc - it.acc, it.lat);
                    end else begin
                        chk(model_rd(it.addr) == it.data, "R8 write stored", model_rd(it.addr), it.data);
                        chk(cyc - it.acc == it.lat, "R8 write latency", cyc - it.acc, it.lat);
                    end
                end
            end
            if (ready_o) chk(mem_cs_n_o == 1'b1, "R7 standby select", mem_cs_n_o, 1);
            if (!mem_oe_n_o) chk(mem_we_n_o && !mem_cs_n_o, "R3 read strobes", {mem_we_n_o, mem_cs_n_o}, 2);
            if (mem_dq_oe_o) chk(!mem_we_n_o && !prev_we_n, "R5 driver inside pulse", mem_we_n_o, 0);
            if (!mem_we_n_o) begin
                chk(!mem_cs_n_o, "R9 select with write", mem_cs_n_o, 0);
                chk(mem_oe_n_o, "R4 output enable high", mem_oe_n_o, 1);
                if (!prev_we_n) chk(mem_addr_o == we_addr, "R6 address stable", mem_addr_o, we_addr);
                if (prev_we_n) we_addr = mem_addr_o;
                we_cnt++;
                if (mem_dq_oe_o) begin
                    drv_cnt++;
                    mem_m[int'(mem_addr_o)] = mem_dq_o;
                end
            end else if (!prev_we_n) begin
                chk(we_cnt == PULSE, "R4 pulse length", we_cnt, PULSE);
                chk(drv_cnt >= DS, "R5 data setup cycles", drv_cnt, DS);
                we_cnt = 0; drv_cnt = 0;
            end
            prev_we_n = mem_we_n_o;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ready_o && !done_o && mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o,
            "R1 reset state", {ready_o, done_o, mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o}, 6'b101110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && !done_o && mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o,
            "R1 after reset", {ready_o, done_o, mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o}, 6'b101110);

        do_req(1'b1, 15'h0001, 8'h3C, 1'b0);
        do_req(1'b0, 15'h0001, 8'h00, 1'b0);
        do_req(1'b0, 15'h7FFF, 8'h00, 1'b0);   // R3 unwritten top address
        do_req(1'b1, 15'h7FFF, 8'hC3, 1'b0);
        do_req(1'b0, 15'h7FFF, 8'h00, 1'b0);
        do_req(1'b1, 15'h0000, 8'hFF, 1'b0);
        do_req(1'b0, 15'h0000, 8'h00, 1'b0);
        // R2: a write raised while busy must not reach the memory.
        do_req(1'b1, 15'h1234, 8'h11, 1'b1);
        do_req(1'b0, 15'h1234, 8'h00, 1'b0);
        do_req(1'b0, 15'h4321, 8'h00, 1'b0);
        for (int i = 0; i < 16; i++)
            do_req(1'b1, 15'((i * 2053) & 32'h7FFF), 8'((i * 17 + 3) & 255), 1'b0);
        for (int i = 0; i < 16; i++)
            do_req(1'b0, 15'((i * 2053) & 32'h7FFF), 8'h00, 1'b0);

        for (int k = 0; k < 50 && sb_q.size() != 0; k++) @(negedge clk);
        chk(sb_q.size() == 0, "R8 all accesses completed", sb_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule